// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the module clock into the bit-level timing grid of a CAN node. A prescaler cuts the module clock down to a time-quantum tick. The bit timer counts those quanta through four segments in order: a fixed one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. It pulses a sample strobe when phase segment 1 closes and a transmit-point strobe when a new sync segment opens. The bit value present on the line at the sample point is held on an output.

The received line passes through a two-flop synchroniser. The block then looks for recessive-to-dominant (1 to 0) transitions on it. While the bus is idle, such an edge hard-synchronises the timer so that the bit restarts just after its sync segment. Inside a frame, the edge instead resynchronises the timer. An early edge, seen in the propagation segment or in phase segment 1, stretches phase segment 1. A late edge, seen in phase segment 2, trims phase segment 2. Either correction is capped by a programmable jump width, and only one correction is made per bit.

The timing fields are written through a plain write strobe and take effect only while the block is frozen. A soft reset restarts the timer but keeps the fields. A hard reset clears the fields to zero.

Top module: `can_bittime_gen`

## Requirements
- R1: One time quantum lasts `cfg_presc + 1` module clocks. `tq_tick` pulses for one clock at the end of each quantum, so a value of 0 ticks every clock and a value of 255 ticks every 256 clocks.
- R2: A bit lasts 1 + (`cfg_prop`+1) + (`cfg_ph1`+1) + (`cfg_ph2`+1) quanta. `sample_stb` is high for the one clock whose tick closes phase segment 1. `tx_stb` is high for the one clock whose tick closes phase segment 2, after which the sync segment begins.
- R3: The fields are loaded only in a cycle where both `freeze` and `cfg_we` are high. A write attempted while `freeze` is low leaves the bit timing unchanged.
- R4: While `freeze` or `soft_rst` is high, `tq_tick`, `sample_stb` and `tx_stb` stay low. On release, the timer starts again from the beginning of a sync segment.
- R5: `soft_rst` leaves the loaded fields intact. A hard reset (`rst_n` low) returns every field to zero, which gives a 4-quantum bit of 1 clock per quantum.
- R6: `rx_in` passes through two flops before edge detection. Only a 1-to-0 change of the synchronised line counts as an edge, and a 0-to-1 change has no effect on timing.
- R7: An edge seen while `bus_idle` is high restarts the prescaler and places the timer at the first quantum of the propagation segment.
- R8: An edge seen during a frame in the propagation segment or in phase segment 1 lengthens phase segment 1 by min(e, `cfg_sjw`+1). Here e is the edge's quantum position counted from 1 at the first propagation quantum.
- R9: An edge seen during a frame in phase segment 2 shortens that segment by min(r, `cfg_sjw`+1). Here r is the number of phase segment 2 quanta not yet completed. If nothing is left, the segment closes at the next tick.
- R10: At most one resynchronisation is applied per bit. Further edges before the next `tx_stb` are ignored.
- R11: `rx_bit` resets to 1. It takes the synchronised line value on each `sample_stb`, is updated in the following clock, and holds that value until the next sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Hard reset, active low, clears fields and timer |
| soft_rst | input | 1 | Soft reset, restarts timer, keeps fields |
| freeze | input | 1 | Holds the timer stopped and opens the field write path |
| cfg_we | input | 1 | Field write strobe |
| cfg_presc | input | 8 | Prescaler field, quantum = value+1 clocks |
| cfg_sjw | input | 2 | Jump width field, cap = value+1 quanta |
| cfg_prop | input | 3 | Propagation segment field, value+1 quanta |
| cfg_ph1 | input | 3 | Phase segment 1 field, value+1 quanta |
| cfg_ph2 | input | 3 | Phase segment 2 field, value+1 quanta |
| bus_idle | input | 1 | High when no frame is in progress (selects hard sync) |
| rx_in | input | 1 | Received bus line, 1 recessive, 0 dominant |
| tq_tick | output | 1 | Time-quantum tick |
| sample_stb | output | 1 | Sample-point strobe |
| tx_stb | output | 1 | Transmit-point strobe |
| rx_bit | output | 1 | Bit value taken at the last sample point |

## Verification
Both strobes are combinational on the clock that carries the closing quantum tick, so they show up in the same cycle as that tick. `rx_bit` follows one clock after `sample_stb`. A change on `rx_in` is seen by the edge detector two clocks after it is driven, and any correction takes effect from the third clock. Every expected strobe cycle is computed as an offset from an observed `tx_stb`, counting these register stages and the quantum length. Line edges are placed so that the detector sees them in a cycle without a tick. The scoreboard then matches each strobe the design produces against the exact cycle number and kind it predicts.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  parameter int unsigned PRESC_W = 8;
  parameter int unsigned SJW_W   = 2;
  parameter int unsigned SEG_W   = 3;
  // quantum counter width: holds a stretched phase segment and an error value
  localparam int unsigned QW = SEG_W + 2;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [SJW_W-1:0]   sjw;
    logic [SEG_W-1:0]   prop;
    logic [SEG_W-1:0]   ph1;
    logic [SEG_W-1:0]   ph2;
  } bt_cfg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  // a segment field encodes length minus one
  function automatic logic [QW-1:0] field_len(input logic [SEG_W-1:0] f);
    return QW'(f) + QW'(1);
  endfunction

  function automatic logic [QW-1:0] jump_len(input logic [SJW_W-1:0] f);
    return QW'(f) + QW'(1);
  endfunction

  function automatic logic [QW-1:0] min_q(input logic [QW-1:0] a,
                                          input logic [QW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // early edge: quantum position counted from 1 at the first propagation quantum
  function automatic logic [QW-1:0] lead_err(input seg_e s,
                                             input logic [QW-1:0] q,
                                             input logic [SEG_W-1:0] prop);
    if (s == SEG_PROP) return q + QW'(1);
    return field_len(prop) + q + QW'(1);
  endfunction

  // late edge: phase segment 2 quanta not yet completed
  function automatic logic [QW-1:0] lag_err(input logic [QW-1:0] q,
                                            input logic [SEG_W-1:0] ph2);
    return field_len(ph2) - q;
  endfunction

  function automatic seg_e next_seg(input seg_e s);
    case (s)
      SEG_SYNC: return SEG_PROP;
      SEG_PROP: return SEG_PH1;
      SEG_PH1:  return SEG_PH2;
      default:  return SEG_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    freeze,
  input  logic    we,
  input  bt_cfg_t din,
  output bt_cfg_t cfg_q
);

  logic load;
  assign load = freeze && we;

  // only the hard reset clears the fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= din;
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(freeze && we) |=> $stable(cfg_q));

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] pcnt_q;
  logic         wrap;

  assign wrap = (pcnt_q == div);
  assign tick = run && !clr && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt_q <= '0;
    else if (!run || clr)  pcnt_q <= '0;
    else if (wrap)         pcnt_q <= '0;
    else                   pcnt_q <= pcnt_q + W'(1);
  end

  // R1
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pcnt_q == '0);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tick) |=> pcnt_q == $past(pcnt_q) + W'(1));

endmodule

// File: rtl/can_bt_sync.sv
module can_bt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s,
  output logic fall_edge
);

  logic meta_q, sync_q, prev_q;

  // line idles recessive, so all stages reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s      = sync_q;
  assign fall_edge = prev_q && !sync_q;

  // R6
  fall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_s) |-> fall_edge);

  // R6
  rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_s) |-> !fall_edge);

endmodule

// File: rtl/can_bt_fsm.sv
module can_bt_fsm
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             fall_edge,
  input  logic             bus_idle,
  input  logic             rx_s,
  input  logic [SJW_W-1:0] sjw,
  input  logic [SEG_W-1:0] prop,
  input  logic [SEG_W-1:0] ph1,
  input  logic [SEG_W-1:0] ph2,
  output logic             hsync,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             rx_bit
);

  seg_e          seg_q;
  logic [QW-1:0] qcnt_q;
  logic [QW-1:0] ext_q;
  logic [QW-1:0] shr_q;
  logic          done_q;
  logic          rx_bit_q;

  logic [QW-1:0] seg_len;
  logic [QW-1:0] jump;
  logic          seg_last;
  logic          resync_ok;

  assign jump = jump_len(sjw);

  always_comb begin
    case (seg_q)
      SEG_SYNC: seg_len = QW'(1);
      SEG_PROP: seg_len = field_len(prop);
      SEG_PH1:  seg_len = field_len(ph1) + ext_q;
      default:  seg_len = field_len(ph2) - shr_q;
    endcase
  end

  // a shortened phase 2 may already be used up: close at the next tick
  assign seg_last   = (qcnt_q + QW'(1)) >= seg_len;
  assign sample_stb = tick && (seg_q == SEG_PH1) && seg_last;
  assign tx_stb     = tick && (seg_q == SEG_PH2) && seg_last;
  assign hsync      = run && fall_edge && bus_idle;
  assign resync_ok  = run && fall_edge && !bus_idle && !done_q && !tx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      shr_q    <= '0;
      done_q   <= 1'b0;
      rx_bit_q <= 1'b1;
    end else if (!run) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      done_q <= 1'b0;
    end else if (hsync) begin
      seg_q  <= SEG_PROP;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick) begin
        if (seg_last) begin
          qcnt_q <= '0;
          seg_q  <= next_seg(seg_q);
          if (seg_q == SEG_PH2) begin
            ext_q  <= '0;
            shr_q  <= '0;
            done_q <= 1'b0;
          end
        end else begin
          qcnt_q <= qcnt_q + QW'(1);
        end
      end
      if (resync_ok) begin
        done_q <= 1'b1;
        if (seg_q == SEG_PROP || seg_q == SEG_PH1)
          ext_q <= min_q(lead_err(seg_q, qcnt_q, prop), jump);
        else if (seg_q == SEG_PH2)
          shr_q <= min_q(lag_err(qcnt_q, ph2), jump);
      end
      if (sample_stb) rx_bit_q <= rx_s;
    end
  end

  assign rx_bit = rx_bit_q;

  // R2
  sample_to_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (seg_q == SEG_PH2) && (qcnt_q == '0));

  // R2
  tx_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> (seg_q == SEG_SYNC) && (qcnt_q == '0));

  // R2
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  // R4
  quiet_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sample_stb && !tx_stb);

  // R7
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (seg_q == SEG_PROP) && (qcnt_q == '0));

  // R8
  jump_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q <= jump) && (shr_q <= jump));

  // R10
  one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run && !hsync && !tx_stb) |=> done_q);

  // R11
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(rx_bit_q));

endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen
  import can_bt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               freeze,
  input  logic               cfg_we,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [SJW_W-1:0]   cfg_sjw,
  input  logic [SEG_W-1:0]   cfg_prop,
  input  logic [SEG_W-1:0]   cfg_ph1,
  input  logic [SEG_W-1:0]   cfg_ph2,
  input  logic               bus_idle,
  input  logic               rx_in,
  output logic               tq_tick,
  output logic               sample_stb,
  output logic               tx_stb,
  output logic               rx_bit
);

  bt_cfg_t wr_cfg;
  bt_cfg_t cfg;
  logic    run;
  logic    rx_s;
  logic    fall_edge;
  logic    hsync;

  assign run = !freeze && !soft_rst;

  assign wr_cfg = '{presc: cfg_presc, sjw: cfg_sjw, prop: cfg_prop,
                    ph1: cfg_ph1, ph2: cfg_ph2};

  can_bt_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (freeze),
    .we     (cfg_we),
    .din    (wr_cfg),
    .cfg_q  (cfg)
  );

  can_bt_presc #(.W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (hsync),
    .div   (cfg.presc),
    .tick  (tq_tick)
  );

  can_bt_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .rx_s      (rx_s),
    .fall_edge (fall_edge)
  );

  can_bt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tq_tick),
    .fall_edge  (fall_edge),
    .bus_idle   (bus_idle),
    .rx_s       (rx_s),
    .sjw        (cfg.sjw),
    .prop       (cfg.prop),
    .ph1        (cfg.ph1),
    .ph2        (cfg.ph2),
    .hsync      (hsync),
    .sample_stb (sample_stb),
    .tx_stb     (tx_stb),
    .rx_bit     (rx_bit)
  );

endmodule

// File: tb/can_bittime_gen_tb.sv
module can_bittime_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       freeze = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_presc = '0;
  logic [1:0] cfg_sjw = '0;
  logic [2:0] cfg_prop = '0;
  logic [2:0] cfg_ph1 = '0;
  logic [2:0] cfg_ph2 = '0;
  logic       bus_idle = 1'b0;
  logic       rx_in = 1'b1;
  logic       tq_tick, sample_stb, tx_stb, rx_bit;

  // 4 ns period -> 250 MHz
  always #2 clk = ~clk;

  can_bittime_gen u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .freeze(freeze),
    .cfg_we(cfg_we), .cfg_presc(cfg_presc), .cfg_sjw(cfg_sjw),
    .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2),
    .bus_idle(bus_idle), .rx_in(rx_in), .tq_tick(tq_tick),
    .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    bit          is_tx;
    int unsigned at;
    string       req;
  } exp_t;

  exp_t expq[$];
  bit   armed = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe while armed must match the queue head
  always @(negedge clk) begin
    exp_t e;
    if (armed && (sample_stb || tx_stb)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected strobe at cycle", cyc, 0);
      end else begin
        e = expq.pop_front();
        chk((e.at == cyc) && (e.is_tx == tx_stb), e.req,
            e.is_tx ? "transmit strobe cycle" : "sample strobe cycle",
            (e.is_tx == tx_stb) ? cyc : -1, e.at);
      end
    end
  end

  task automatic push(input bit is_tx, input int unsigned at, input string req);
    exp_t e;
    e.is_tx = is_tx;
    e.at    = at;
    e.req   = req;
    expq.push_back(e);
  endtask

  task automatic wait_tx(output int unsigned t);
    do @(negedge clk); while (!tx_stb);
    t = cyc;
    #1;
  endtask

  task automatic wait_cyc(input int unsigned c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic arm();
    armed = 1'b1;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    #1;
    armed = 1'b0;
  endtask

  task automatic cfg_load(input int p, input int sj, input int pr,
                          input int p1, input int p2);
    int q;
    @(negedge clk);
    freeze    = 1'b1;
    cfg_presc = 8'(p);
    cfg_sjw   = 2'(sj);
    cfg_prop  = 3'(pr);
    cfg_ph1   = 3'(p1);
    cfg_ph2   = 3'(p2);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    q = 0;
    repeat (6) begin
      @(negedge clk);
      if (tq_tick || sample_stb || tx_stb) q++;
    end
    // R4: nothing moves while frozen
    chk(q == 0, "R4", "strobes while frozen", q, 0);
    freeze = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
    finish_up();
  end

  initial begin
    int unsigned t;
    int          n;

    // reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tq_tick && !sample_stb && !tx_stb, "R4", "outputs after reset",
        {tq_tick, sample_stb, tx_stb}, 0);
    // R11: recessive after reset
    chk(rx_bit == 1'b1, "R11", "rx_bit after reset", rx_bit, 1);

    // R5: zero fields after hard reset give a 4-clock bit
    freeze = 1'b0;
    wait_tx(t);
    push(0, t + 3, "R5"); push(1, t + 4, "R5");
    push(0, t + 7, "R2"); push(1, t + 8, "R2");
    arm(); drain();

    // R2 / R1: presc 1, prop 2q, ph1 3q, ph2 2q -> 16 clocks per bit
    cfg_load(1, 0, 1, 2, 1);
    wait_tx(t);
    push(0, t + 12, "R2"); push(1, t + 16, "R2");
    push(0, t + 28, "R2"); push(1, t + 32, "R2");
    arm();
    n = 0;
    repeat (16) begin
      @(negedge clk);
      if (tq_tick) n++;
    end
    // R1: a quantum every 2 clocks
    chk(n == 8, "R1", "ticks in 16 clocks", n, 8);
    drain();

    // R3: write while running is ignored
    @(negedge clk);
    cfg_presc = 8'd0; cfg_prop = 3'd5; cfg_ph1 = 3'd0; cfg_ph2 = 3'd6;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_tx(t);
    push(0, t + 12, "R3"); push(1, t + 16, "R3");
    arm(); drain();

    // R8: early edge in first propagation quantum stretches phase 1 by 1
    wait_tx(t);
    push(0, t + 14, "R8"); push(1, t + 18, "R8");
    push(0, t + 30, "R6"); push(1, t + 34, "R6");
    arm();
    wait_cyc(t + 1);  rx_in = 1'b0;
    wait_cyc(t + 16);
    chk(rx_bit == 1'b0, "R11", "rx_bit after dominant sample", rx_bit, 0);
    wait_cyc(t + 20); rx_in = 1'b1;  // R6: rising edge leaves timing alone
    wait_cyc(t + 25);
    chk(rx_bit == 1'b0, "R11", "rx_bit held between samples", rx_bit, 0);
    wait_cyc(t + 32);
    chk(rx_bit == 1'b1, "R11", "rx_bit after recessive sample", rx_bit, 1);
    drain();

    // R10: second falling edge in the same bit is ignored (jump width 4)
    cfg_load(1, 3, 1, 2, 1);
    wait_tx(t);
    push(0, t + 14, "R10"); push(1, t + 18, "R10");
    arm();
    wait_cyc(t + 1);  rx_in = 1'b0;
    wait_cyc(t + 3);  rx_in = 1'b1;
    wait_cyc(t + 5);  rx_in = 1'b0;
    wait_cyc(t + 20); rx_in = 1'b1;
    drain();

    // R8: edge at position 4 capped to jump width 2
    cfg_load(1, 1, 1, 2, 1);
    wait_tx(t);
    push(0, t + 16, "R8"); push(1, t + 20, "R8");
    arm();
    wait_cyc(t + 7);  rx_in = 1'b0;
    wait_cyc(t + 22); rx_in = 1'b1;
    drain();

    // R9: late edge, 4 quanta left, cap 1 -> phase 2 becomes 3 quanta
    cfg_load(1, 0, 1, 2, 3);
    wait_tx(t);
    push(0, t + 12, "R9"); push(1, t + 18, "R9");
    arm();
    wait_cyc(t + 11); rx_in = 1'b0;
    wait_cyc(t + 20); rx_in = 1'b1;
    drain();

    // R9: same edge with cap 4 -> phase 2 used up, closes at next tick
    cfg_load(1, 3, 1, 2, 3);
    wait_tx(t);
    push(0, t + 12, "R9"); push(1, t + 14, "R9");
    arm();
    wait_cyc(t + 11); rx_in = 1'b0;
    wait_cyc(t + 20); rx_in = 1'b1;
    drain();

    // R7: edge while idle hard-syncs
    cfg_load(1, 0, 1, 2, 1);
    bus_idle = 1'b1;
    wait_tx(t);
    push(0, t + 13, "R7"); push(1, t + 17, "R7");
    arm();
    wait_cyc(t + 1);  rx_in = 1'b0;
    wait_cyc(t + 20); rx_in = 1'b1;
    drain();
    bus_idle = 1'b0;

    // R5: soft reset keeps fields
    @(negedge clk);
    soft_rst = 1'b1;
    n = 0;
    repeat (5) begin
      @(negedge clk);
      if (tq_tick || sample_stb || tx_stb) n++;
    end
    chk(n == 0, "R4", "strobes during soft reset", n, 0);
    soft_rst = 1'b0;
    wait_tx(t);
    push(0, t + 12, "R5"); push(1, t + 16, "R5");
    arm(); drain();

    // R5: hard reset clears fields
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_tx(t);
    push(0, t + 3, "R5"); push(1, t + 4, "R5");
    arm(); drain();

    // R1: divide by 256, minimum segments -> 1024 clocks per bit
    cfg_load(255, 0, 0, 0, 0);
    wait_tx(t);
    push(0, t + 768, "R1"); push(1, t + 1024, "R1");
    arm(); drain();

    finish_up();
  end

endmodule